// File: doc/BRIEF.md
# Dispatch Stage with Skid Buffer

The dispatch stage sits between renaming and the out-of-order back end of one hardware thread. Each cycle it takes up to `LANES` renamed instruction records and hands each one to the right downstream structure. Loads get a load-queue slot and an issue-queue slot. Plain stores and ALU operations go to the issue queue. Store-conditionals, atomics and serializing operations go to the non-speculative list. Fences go in as barriers, and no-ops retire on the spot. Records that are already marked dead are dropped, but they are still counted so that upstream credit bookkeeping stays balanced.

A status register tracks six states. Commit can kill everything in flight with a squash request. Commit can also hold the stage still while its own recovery is running. When the issue queue, the load queue or the store queue cannot take the next record, the stage stalls. The undispatched records, and any records that arrive while the stage is stalled, wait in a skid buffer. On recovery the skid buffer drains before new input is taken, so program order is kept. Every cycle the stage reports upstream the dispatched count, the load and store slot counts, an unblock flag and the number of free skid entries.

Top module: `dispatch_stage`

## Requirements
- R1: After reset the stage reports Idle, a fully free skid buffer, no valid output lanes and zero counts. The status encoding is Running=0, Blocked=1, Idle=2, StartSquash=3, Squashing=4, Unblocking=5.
- R2: While `squash_req` is high, nothing is dispatched, the incoming records are discarded and the skid buffer is emptied. The status becomes Squashing, and the next cycle shows a fully free skid buffer.
- R3: While `commit_busy` is high and `squash_req` is low, the stage behaves the same way: no dispatch, input discarded, skid buffer emptied, status Squashing.
- R4: Without squash or busy, `iq_free`=0 makes the stage Blocked for that cycle. Nothing is dispatched, `unblock` is low, and every incoming record is appended to the skid buffer.
- R5: With no squash, no busy and `iq_free`>0, the effective state is derived from the registered status. A Blocked stage acts as Running when the skid buffer is empty and as Unblocking otherwise. Squashing becomes Running. Idle, Running and Unblocking are kept.
- R6: In Unblocking the records come from the head of the skid buffer, and new input is appended behind them. In Idle or Running the records come from the input lanes. Records are handled strictly in order, at most `LANES` per cycle. Output lane i carries the i-th handled record and its tag.
- R7: A dead record (`in_dead`=1) is not output (lane valid low), but it counts in `disp_cnt`. It also counts in `lq_cnt` if its class is load, and in `sq_cnt` if its class is store, store-conditional or atomic.
- R8: The class encoding is ALU=0, LOAD=1, STORE=2, STCOND=3, ATOMIC=4, FENCE=5, NOP=6, SERIAL=7. The route encoding is issue=0 for ALU, LOAD and STORE; non-speculative=1 for STCOND, ATOMIC and SERIAL; barrier=2 for FENCE; retired-at-dispatch=3 for NOP.
- R9: Handling stops at the first live record that meets any of these conditions: no issue-queue room is left, it is a load and no load-queue room is left, or it is a store, store-conditional or atomic and no store-queue room is left. Room is the free input minus the slots already taken this cycle; a NOP takes no issue slot. That record and all later ones are kept in order in the skid buffer, the next status is Blocked and `unblock` is low.
- R10: If skid-buffer records remain after a cycle in Unblocking because of the lane limit, the next status is Blocked and `unblock` is low.
- R11: An Idle stage that handles at least one record (dead ones included) without stalling becomes Running.
- R12: `skid_free` equals the skid depth minus its occupancy, updated at each clock edge.
- R13: `unblock` is high exactly when the effective state is Idle, Running or Unblocking and no record is left behind that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_cnt | input | $clog2(LANES+1) | Number of valid incoming records on lanes 0.. |
| in_cls | input | 3*LANES | Class code per incoming lane |
| in_dead | input | LANES | Record already squashed, per lane |
| in_tag | input | TAG_W*LANES | Record tag per lane |
| squash_req | input | 1 | Squash request from commit |
| commit_busy | input | 1 | Commit still recovering from a squash |
| iq_free | input | FREE_W | Free issue-queue entries |
| lq_free | input | FREE_W | Free load-queue entries |
| sq_free | input | FREE_W | Free store-queue entries |
| out_valid | output | LANES | Record inserted or retired on this lane |
| out_route | output | 2*LANES | Route code per lane |
| out_tag | output | TAG_W*LANES | Tag of the record on each lane |
| disp_cnt | output | $clog2(LANES+1) | Records handled this cycle, dead ones included |
| lq_cnt | output | $clog2(LANES+1) | Load-queue allocations reported this cycle |
| sq_cnt | output | $clog2(LANES+1) | Store-queue allocations reported this cycle |
| unblock | output | 1 | Upstream may continue normally |
| skid_free | output | $clog2(SKID_DEPTH+1) | Free skid-buffer entries |
| status | output | 3 | Registered stage status |

## Verification
The hardest case to reach is Unblocking combined with a mid-group resource stall while upstream keeps delivering records. Here the pop count, the append position and the next status all depend on each other. The stimulus keeps the free counts of the three queues small and often zero, and feeds upstream right up to the reported `skid_free` limit. This keeps the skid buffer full for long stretches, so stalls keep landing partway through a skid drain. Dead records, every class, squash and busy pulses are mixed in at phase-dependent rates. A bench model built from the requirements predicts every lane, count, flag and status.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

    parameter int TAG_W = 8;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_BLOCKED   = 3'd1,
        ST_IDLE      = 3'd2,
        ST_STARTSQ   = 3'd3,
        ST_SQUASHING = 3'd4,
        ST_UNBLOCK   = 3'd5
    } stage_st_e;

    typedef enum logic [2:0] {
        CL_ALU    = 3'd0,
        CL_LOAD   = 3'd1,
        CL_STORE  = 3'd2,
        CL_STCOND = 3'd3,
        CL_ATOMIC = 3'd4,
        CL_FENCE  = 3'd5,
        CL_NOP    = 3'd6,
        CL_SERIAL = 3'd7
    } op_cls_e;

    typedef enum logic [1:0] {
        RT_ISSUE   = 2'd0,
        RT_NONSPEC = 2'd1,
        RT_FENCE   = 2'd2,
        RT_RETIRED = 2'd3
    } route_e;

    typedef struct packed {
        op_cls_e          cls;
        logic             dead;
        logic [TAG_W-1:0] tag;
    } rec_t;

    // A no-op never occupies an issue-queue slot.
    function automatic logic takes_iq(op_cls_e c);
        return c != CL_NOP;
    endfunction

    function automatic logic takes_lq(op_cls_e c);
        return c == CL_LOAD;
    endfunction

    function automatic logic takes_sq(op_cls_e c);
        return (c == CL_STORE) || (c == CL_STCOND) || (c == CL_ATOMIC);
    endfunction

    function automatic route_e route_of(op_cls_e c);
        case (c)
            CL_STCOND, CL_ATOMIC, CL_SERIAL: return RT_NONSPEC;
            CL_FENCE:                        return RT_FENCE;
            CL_NOP:                          return RT_RETIRED;
            default:                         return RT_ISSUE;
        endcase
    endfunction

endpackage

// File: rtl/dsp_skid_fifo.sv
module dsp_skid_fifo
    import dsp_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LANES = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic [$clog2(LANES+1)-1:0]   pop_n,
    input  logic [$clog2(LANES+1)-1:0]   push_n,
    input  rec_t                         push_rec [LANES],
    output rec_t                         head_rec [LANES],
    output logic [$clog2(DEPTH+1)-1:0]   occ
);
    // DEPTH must be a power of two so the pointers wrap naturally.
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    rec_t          mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] occ_q;

    assign occ = occ_q;

    for (genvar g = 0; g < LANES; g++) begin : g_head
        assign head_rec[g] = mem[rd_ptr + PW'(g)];
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ_q  <= '0;
        end else begin
            for (int j = 0; j < LANES; j++) begin
                if (j < int'(push_n)) begin
                    mem[wr_ptr + PW'(j)] <= push_rec[j];
                end
            end
            wr_ptr <= wr_ptr + PW'(push_n);
            rd_ptr <= rd_ptr + PW'(pop_n);
            occ_q  <= occ_q - CW'(pop_n) + CW'(push_n);
        end
    end

    AST_SKID_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        !flush |-> (int'(pop_n) <= int'(occ_q))); // R12
    AST_SKID_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !flush |-> (int'(occ_q) - int'(pop_n) + int'(push_n) <= DEPTH)); // R12

endmodule

// File: rtl/dsp_slot_engine.sv
module dsp_slot_engine
    import dsp_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int FREE_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         enable,
    input  logic [$clog2(LANES+1)-1:0]   src_cnt,
    input  rec_t                         src_rec [LANES],
    input  logic [FREE_W-1:0]            iq_free,
    input  logic [FREE_W-1:0]            lq_free,
    input  logic [FREE_W-1:0]            sq_free,
    output logic [LANES-1:0]             lane_vld,
    output route_e                       lane_rt  [LANES],
    output logic [TAG_W-1:0]             lane_tag [LANES],
    output logic [$clog2(LANES+1)-1:0]   taken,
    output logic [$clog2(LANES+1)-1:0]   lq_n,
    output logic [$clog2(LANES+1)-1:0]   sq_n,
    output logic                         res_stall
);
    localparam int NW = $clog2(LANES + 1);

    always_comb begin
        int  iq_l;
        int  lq_l;
        int  sq_l;
        int  k;
        int  lqc;
        int  sqc;
        logic halt;
        iq_l      = int'(iq_free);
        lq_l      = int'(lq_free);
        sq_l      = int'(sq_free);
        k         = 0;
        lqc       = 0;
        sqc       = 0;
        halt      = 1'b0;
        res_stall = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            lane_vld[i] = 1'b0;
            lane_rt[i]  = RT_ISSUE;
            lane_tag[i] = src_rec[i].tag;
            if (enable && !halt && (i < int'(src_cnt))) begin
                if (src_rec[i].dead) begin
                    k   = k + 1;
                    lqc = lqc + int'(takes_lq(src_rec[i].cls));
                    sqc = sqc + int'(takes_sq(src_rec[i].cls));
                end else if ((iq_l == 0) ||
                             (takes_lq(src_rec[i].cls) && lq_l == 0) ||
                             (takes_sq(src_rec[i].cls) && sq_l == 0)) begin
                    halt      = 1'b1;
                    res_stall = 1'b1;
                end else begin
                    lane_vld[i] = 1'b1;
                    lane_rt[i]  = route_of(src_rec[i].cls);
                    k   = k + 1;
                    if (takes_iq(src_rec[i].cls)) iq_l = iq_l - 1;
                    if (takes_lq(src_rec[i].cls)) begin
                        lq_l = lq_l - 1;
                        lqc  = lqc + 1;
                    end
                    if (takes_sq(src_rec[i].cls)) begin
                        sq_l = sq_l - 1;
                        sqc  = sqc + 1;
                    end
                end
            end
        end
        taken = NW'(k);
        lq_n  = NW'(lqc);
        sq_n  = NW'(sqc);
    end

    // Checker-side count of issue slots the output lanes consumed.
    logic [NW-1:0] iq_used;
    always_comb begin
        iq_used = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_vld[i] && lane_rt[i] != RT_RETIRED) iq_used = iq_used + 1'b1;
        end
    end

    AST_IQ_BUDGET: assert property (@(posedge clk) disable iff (rst)
        int'(iq_used) <= int'(iq_free)); // R9
    AST_IDLE_LANES: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (lane_vld == '0 && taken == '0)); // R6

endmodule

// File: rtl/dsp_status_fsm.sv
module dsp_status_fsm
    import dsp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      squash_req,
    input  logic      commit_busy,
    input  logic      iq_none,
    input  logic      skid_empty,
    input  logic      any_taken,
    input  logic      block_now,
    input  logic      skid_empty_after,
    output stage_st_e eff_st,
    output stage_st_e cur_st
);
    stage_st_e st_q;
    stage_st_e st_d;

    assign cur_st = st_q;

    // Signals from commit and downstream override the held status.
    always_comb begin
        if (squash_req || commit_busy) begin
            eff_st = ST_SQUASHING;
        end else if (iq_none) begin
            eff_st = ST_BLOCKED;
        end else begin
            case (st_q)
                ST_BLOCKED:               eff_st = skid_empty ? ST_RUN : ST_UNBLOCK;
                ST_SQUASHING, ST_STARTSQ: eff_st = ST_RUN;
                default:                  eff_st = st_q;
            endcase
        end
    end

    always_comb begin
        if (eff_st == ST_SQUASHING || eff_st == ST_BLOCKED) begin
            st_d = eff_st;
        end else if (block_now) begin
            st_d = ST_BLOCKED;
        end else if (eff_st == ST_UNBLOCK && skid_empty_after) begin
            st_d = ST_RUN;
        end else if (eff_st == ST_IDLE && any_taken) begin
            st_d = ST_RUN;
        end else begin
            st_d = eff_st;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    AST_SQUASH_STATE: assert property (@(posedge clk) disable iff (rst)
        (squash_req || commit_busy) |=> (cur_st == ST_SQUASHING)); // R2
    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (rst)
        (eff_st == ST_IDLE && any_taken && !block_now) |=> (cur_st == ST_RUN)); // R11
    AST_SQ_RECOVER: assert property (@(posedge clk) disable iff (rst)
        (cur_st == ST_SQUASHING && !squash_req && !commit_busy && !iq_none && !block_now)
        |=> (cur_st == ST_RUN)); // R5

endmodule

// File: rtl/dispatch_stage.sv
module dispatch_stage
    import dsp_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int SKID_DEPTH = 8,
    parameter int FREE_W     = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [$clog2(LANES+1)-1:0]        in_cnt,
    input  logic [3*LANES-1:0]                in_cls,
    input  logic [LANES-1:0]                  in_dead,
    input  logic [TAG_W*LANES-1:0]            in_tag,
    input  logic                              squash_req,
    input  logic                              commit_busy,
    input  logic [FREE_W-1:0]                 iq_free,
    input  logic [FREE_W-1:0]                 lq_free,
    input  logic [FREE_W-1:0]                 sq_free,
    output logic [LANES-1:0]                  out_valid,
    output logic [2*LANES-1:0]                out_route,
    output logic [TAG_W*LANES-1:0]            out_tag,
    output logic [$clog2(LANES+1)-1:0]        disp_cnt,
    output logic [$clog2(LANES+1)-1:0]        lq_cnt,
    output logic [$clog2(LANES+1)-1:0]        sq_cnt,
    output logic                              unblock,
    output logic [$clog2(SKID_DEPTH+1)-1:0]   skid_free,
    output logic [2:0]                        status
);
    localparam int NW = $clog2(LANES + 1);
    localparam int OW = $clog2(SKID_DEPTH + 1);

    rec_t             in_rec   [LANES];
    rec_t             head_rec [LANES];
    rec_t             src_rec  [LANES];
    rec_t             push_rec [LANES];
    route_e           lane_rt  [LANES];
    logic [TAG_W-1:0] lane_tag [LANES];
    logic [LANES-1:0] lane_vld;

    logic [OW-1:0] occ;
    logic [NW-1:0] taken, lq_n, sq_n, src_cnt, pop_n, push_n;
    logic          res_stall, flush, from_skid, engaged, leftover, skid_after_empty;
    stage_st_e     eff_st, cur_st;
    int            in_n, avail;

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign in_rec[g].cls  = op_cls_e'(in_cls[3*g +: 3]);
        assign in_rec[g].dead = in_dead[g];
        assign in_rec[g].tag  = in_tag[TAG_W*g +: TAG_W];
        assign src_rec[g]     = from_skid ? head_rec[g] : in_rec[g];
    end

    assign flush     = squash_req || commit_busy;
    assign from_skid = (eff_st == ST_UNBLOCK);
    assign engaged   = (eff_st == ST_RUN) || (eff_st == ST_IDLE) || (eff_st == ST_UNBLOCK);
    assign in_n      = (int'(in_cnt) > LANES) ? LANES : int'(in_cnt);
    assign avail     = from_skid ? int'(occ) : in_n;
    assign src_cnt   = NW'((avail > LANES) ? LANES : avail);
    assign leftover  = engaged && (avail > int'(taken));
    assign pop_n     = from_skid ? taken : '0;

    // Records that wait: all input while blocked or draining, the unhandled tail otherwise.
    always_comb begin
        int base;
        int cnt;
        base = 0;
        cnt  = 0;
        if (!flush) begin
            if (eff_st == ST_BLOCKED || eff_st == ST_UNBLOCK) begin
                cnt = in_n;
            end else if (eff_st == ST_RUN || eff_st == ST_IDLE) begin
                base = int'(taken);
                cnt  = in_n - int'(taken);
            end
        end
        push_n = NW'(cnt);
        for (int j = 0; j < LANES; j++) begin
            push_rec[j] = '0;
            if (j < cnt && (j + base) < LANES) push_rec[j] = in_rec[j + base];
        end
    end

    assign skid_after_empty = (int'(occ) - int'(pop_n) + int'(push_n)) == 0;

    dsp_status_fsm i_fsm (
        .clk              (clk),
        .rst              (rst),
        .squash_req       (squash_req),
        .commit_busy      (commit_busy),
        .iq_none          (iq_free == '0),
        .skid_empty       (occ == '0),
        .any_taken        (taken != '0),
        .block_now        (leftover),
        .skid_empty_after (skid_after_empty),
        .eff_st           (eff_st),
        .cur_st           (cur_st)
    );

    dsp_skid_fifo #(.DEPTH(SKID_DEPTH), .LANES(LANES)) i_skid (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .pop_n    (pop_n),
        .push_n   (push_n),
        .push_rec (push_rec),
        .head_rec (head_rec),
        .occ      (occ)
    );

    dsp_slot_engine #(.LANES(LANES), .FREE_W(FREE_W)) i_engine (
        .clk       (clk),
        .rst       (rst),
        .enable    (engaged),
        .src_cnt   (src_cnt),
        .src_rec   (src_rec),
        .iq_free   (iq_free),
        .lq_free   (lq_free),
        .sq_free   (sq_free),
        .lane_vld  (lane_vld),
        .lane_rt   (lane_rt),
        .lane_tag  (lane_tag),
        .taken     (taken),
        .lq_n      (lq_n),
        .sq_n      (sq_n),
        .res_stall (res_stall)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_pack
        assign out_route[2*g +: 2]         = lane_rt[g];
        assign out_tag[TAG_W*g +: TAG_W]   = lane_tag[g];
    end

    assign out_valid = lane_vld;
    assign disp_cnt  = taken;
    assign lq_cnt    = lq_n;
    assign sq_cnt    = sq_n;
    assign unblock   = engaged && !leftover;
    assign skid_free = OW'(SKID_DEPTH) - occ;
    assign status    = cur_st;

    AST_BLOCK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (eff_st == ST_BLOCKED) |-> (out_valid == '0 && !unblock)); // R4
    AST_LEFTOVER_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        leftover |=> (cur_st == ST_BLOCKED)); // R10
    AST_SQUASH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        squash_req |=> (int'(skid_free) == SKID_DEPTH)); // R2
    AST_STALL_HAS_TAIL: assert property (@(posedge clk) disable iff (rst)
        res_stall |-> !unblock); // R9

endmodule

// File: tb/test_dispatch_stage.sv
module test_dispatch_stage;
    localparam int LN = 4;
    localparam int SD = 8;
    localparam int FW = 4;
    localparam int TW = 8;
    localparam int S_RUN = 0, S_BLK = 1, S_IDLE = 2, S_SQ = 4, S_UNB = 5;

    logic                 clk = 1'b0;
    logic                 rst;
    logic [2:0]           in_cnt;
    logic [3*LN-1:0]      in_cls;
    logic [LN-1:0]        in_dead;
    logic [TW*LN-1:0]     in_tag;
    logic                 squash_req, commit_busy;
    logic [FW-1:0]        iq_free, lq_free, sq_free;
    logic [LN-1:0]        out_valid;
    logic [2*LN-1:0]      out_route;
    logic [TW*LN-1:0]     out_tag;
    logic [2:0]           disp_cnt, lq_cnt, sq_cnt;
    logic                 unblock;
    logic [3:0]           skid_free;
    logic [2:0]           status;

    dispatch_stage #(.LANES(LN), .SKID_DEPTH(SD), .FREE_W(FW)) i_dispatch_stage (
        .clk(clk), .rst(rst), .in_cnt(in_cnt), .in_cls(in_cls), .in_dead(in_dead),
        .in_tag(in_tag), .squash_req(squash_req), .commit_busy(commit_busy),
        .iq_free(iq_free), .lq_free(lq_free), .sq_free(sq_free),
        .out_valid(out_valid), .out_route(out_route), .out_tag(out_tag),
        .disp_cnt(disp_cnt), .lq_cnt(lq_cnt), .sq_cnt(sq_cnt), .unblock(unblock),
        .skid_free(skid_free), .status(status)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct { int cls; bit dead; int tag; } mrec_t;
    mrec_t skidq[$];
    int    m_state;
    string why;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    function automatic int rnd(int m);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return int'(lfsr[15:0]) % m;
    endfunction

    task automatic chk(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_lq(int c); return c == 1; endfunction
    function automatic bit is_sq(int c); return c == 2 || c == 3 || c == 4; endfunction
    function automatic int rt_of(int c);
        if (c == 3 || c == 4 || c == 7) return 1;
        if (c == 5) return 2;
        if (c == 6) return 3;
        return 0;
    endfunction

    task automatic do_reset();
        rst = 1'b1; in_cnt = '0; in_cls = '0; in_dead = '0; in_tag = '0;
        squash_req = 1'b0; commit_busy = 1'b0;
        iq_free = 4'd4; lq_free = 4'd4; sq_free = 4'd4;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        skidq.delete();
        m_state = S_IDLE;
        why = "R5";
        #2;
        chk(int'(status), S_IDLE, "R1 status");
        chk(int'(skid_free), SD, "R1 skid_free");
        chk(int'(out_valid), 0, "R1 out_valid");
        chk(int'(disp_cnt), 0, "R1 disp_cnt");
        chk(int'(unblock), 1, "R1 unblock");
    endtask

    // One cycle: pick stimulus, predict from requirements, compare, advance model.
    task automatic cycle(int p_sq, int p_busy, int p_fmax, int p_dead, int p_zero);
        int    n_in, eff, iqf, lqf, sqf, iql, lql, sqlf, k, lqc, sqc;
        bit    sq, busy, halt, stall, en, left;
        mrec_t inr[LN];
        mrec_t src[$];
        int    e_vld[LN];
        int    e_rt[LN];
        int    e_tag[LN];
        @(negedge clk);
        chk(int'(status), m_state, {why, " status"});
        chk(int'(skid_free), SD - skidq.size(), "R12 skid_free");
        sq   = (rnd(100) < p_sq);
        busy = !sq && (rnd(100) < p_busy);
        iqf  = (rnd(100) < p_zero) ? 0 : rnd(p_fmax + 1);
        lqf  = (rnd(100) < p_zero) ? 0 : rnd(p_fmax + 1);
        sqf  = (rnd(100) < p_zero) ? 0 : rnd(p_fmax + 1);
        n_in = rnd(LN + 1);
        if (n_in > SD - skidq.size()) n_in = SD - skidq.size();
        for (int i = 0; i < LN; i++) begin
            inr[i].cls  = rnd(8);
            inr[i].dead = (rnd(100) < p_dead);
            inr[i].tag  = rnd(256);
            in_cls[3*i +: 3]   = 3'(inr[i].cls);
            in_dead[i]         = inr[i].dead;
            in_tag[TW*i +: TW] = 8'(inr[i].tag);
        end
        in_cnt = 3'(n_in); squash_req = sq; commit_busy = busy;
        iq_free = 4'(iqf); lq_free = 4'(lqf); sq_free = 4'(sqf);

        if (sq || busy)          eff = S_SQ;
        else if (iqf == 0)       eff = S_BLK;
        else if (m_state == S_BLK) eff = (skidq.size() == 0) ? S_RUN : S_UNB;
        else if (m_state == S_SQ)  eff = S_RUN;
        else                     eff = m_state;
        en = (eff == S_RUN || eff == S_IDLE || eff == S_UNB);
        if (eff == S_UNB) src = skidq;
        else for (int i = 0; i < n_in; i++) src.push_back(inr[i]);

        iql = iqf; lql = lqf; sqlf = sqf; k = 0; lqc = 0; sqc = 0; halt = 0; stall = 0;
        for (int i = 0; i < LN; i++) begin
            e_vld[i] = 0; e_rt[i] = 0; e_tag[i] = -1;
            if (en && !halt && i < src.size()) begin
                e_tag[i] = src[i].tag;
                if (src[i].dead) begin
                    k++; lqc += int'(is_lq(src[i].cls)); sqc += int'(is_sq(src[i].cls));
                end else if (iql == 0 || (is_lq(src[i].cls) && lql == 0) ||
                             (is_sq(src[i].cls) && sqlf == 0)) begin
                    halt = 1; stall = 1;
                end else begin
                    e_vld[i] = 1; e_rt[i] = rt_of(src[i].cls); k++;
                    if (src[i].cls != 6) iql--;
                    if (is_lq(src[i].cls)) begin lql--; lqc++; end
                    if (is_sq(src[i].cls)) begin sqlf--; sqc++; end
                end
            end
        end
        left = en && (src.size() > k);

        #2;
        for (int i = 0; i < LN; i++) begin
            chk(int'(out_valid[i]), e_vld[i], stall ? "R9 lane valid" : "R7 lane valid");
            if (e_vld[i] == 1) begin
                chk(int'(out_route[2*i +: 2]), e_rt[i], "R8 route");
                chk(int'(out_tag[TW*i +: TW]), e_tag[i], "R6 tag order");
            end
        end
        chk(int'(disp_cnt), k, "R6 disp_cnt");
        chk(int'(lq_cnt), lqc, "R7 lq_cnt");
        chk(int'(sq_cnt), sqc, "R7 sq_cnt");
        chk(int'(unblock), int'(en && !left),
            stall ? "R9 unblock" : (left ? "R10 unblock" : (eff == S_BLK ? "R4 unblock" : "R13 unblock")));

        if (sq || busy) skidq.delete();
        else if (eff == S_BLK) for (int i = 0; i < n_in; i++) skidq.push_back(inr[i]);
        else if (eff == S_UNB) begin
            for (int i = 0; i < k; i++) void'(skidq.pop_front());
            for (int i = 0; i < n_in; i++) skidq.push_back(inr[i]);
        end else if (en) for (int i = k; i < n_in; i++) skidq.push_back(inr[i]);

        why = "R5";
        if (sq) why = "R2";
        else if (busy) why = "R3";
        else if (eff == S_BLK) why = "R4";
        else if (left) why = stall ? "R9" : "R10";
        else if (eff == S_IDLE && k > 0) why = "R11";

        if (eff == S_SQ || eff == S_BLK) m_state = eff;
        else if (left) m_state = S_BLK;
        else if (eff == S_UNB && skidq.size() == 0) m_state = S_RUN;
        else if (eff == S_IDLE && k > 0) m_state = S_RUN;
        else m_state = eff;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Phase 1: roomy queues, no squashes: plain routing and counting.
        do_reset();
        repeat (2000) cycle(0, 0, 15, 10, 2);
        // Phase 2: tight queues keep the skid buffer full and stalls frequent.
        do_reset();
        repeat (3000) cycle(0, 0, 2, 15, 20);
        // Phase 3: squash and busy pulses mixed with stalls.
        do_reset();
        repeat (3000) cycle(6, 6, 3, 25, 15);
        // Phase 4: mostly dead records, moderate pressure.
        do_reset();
        repeat (2000) cycle(2, 2, 4, 70, 10);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule